// File: doc/BRIEF.md
# Nibble-Tagged Register Command Port

This block sits between a byte-wide command stream and the control registers of a capture engine. Every incoming byte is split into two halves. The upper half is an opcode and the lower half is a 4-bit payload. Some opcodes build up an 8-bit register pointer, half a byte at a time. Another group assembles an 8-bit write value and commits it. Read opcodes return one whole register byte on a separate response stream.

The register space has four parts:
- Two 24-bit position values from the capture side: the trigger point and the stop point. Each is read least significant byte first.
- A mode register. Writing a command code to it starts capture, stops capture, or enables memory readback. Reading it returns a status byte.
- A small bank of plain configuration bytes, which are driven out of the block.

Reads and writes can step the pointer forward, so a host can walk through consecutive registers with one address setup.

Top module: `nibreg_port`

## Requirements
- R1: After reset the register pointer is 0x00. Opcode 0x0 loads the payload into pointer bits 3:0 and opcode 0x1 loads it into pointer bits 7:4. The other pointer half is left unchanged.
- R2: Opcode 0x2 stores the payload as a pending low nibble. Opcode 0x3 writes the byte {payload, pending low nibble} to the register at the pointer, then adds one to the pointer. This lets a burst of data pairs fill consecutive registers.
- R3: Opcode 0x4 (read) and opcode 0x5 (read and step) each put one response byte out in the cycle after acceptance, holding the addressed register's value at acceptance. Opcode 0x5 then adds one to the pointer, wrapping from 0xFF to 0x00. Opcode 0x4 leaves the pointer unchanged.
- R4: Addresses 0x00 to 0x02 return trigger position bytes 0, 1 and 2. Addresses 0x03 to 0x05 return stop position bytes 0, 1 and 2. A read of 0x00 returns the live trigger input and, in the same cycle, takes a snapshot of both positions. Addresses 0x01 to 0x05 return bytes from the most recent snapshot.
- R5: At address 0x06 three write values act on the mode state; all other values leave it unchanged:
  - 0x0D starts capture: run=1, readback=0, trigger flag cleared.
  - 0x11 stops capture: run=0.
  - 0x02 sets readback=1.
- R6: A read of address 0x06 returns a status byte:
  - bit 0 is run.
  - bit 1 is readback.
  - bit 5 is the trigger flag, which is set in any cycle where cap_triggered is high while run is 1.
  - all other bits read 0.
- R7: Addresses 0x08 to 0x0B are configuration bytes that can be read and written. The byte at 0x08+i drives cfg_out[8i+7:8i].
- R8: Writes to 0x00 to 0x05 or to any address with no register are discarded. Reads from an address with no register return 0x00.
- R9: Opcodes 0x6 to 0xF are accepted but have no effect. They do not change the pointer or the pending nibble, and they produce no response.
- R10: A response stays on rsp_byte, unchanged, until rsp_ready takes it. While a response is held and rsp_ready is low, cmd_ready is low. While rsp_ready is high, one command is accepted every cycle, including reads back to back.
- R11: After reset, rsp_valid, cap_run, cap_readback, cfg_out and both snapshots are zero, and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_ready | output | 1 | Command byte accepted this cycle when valid |
| cmd_byte | input | 8 | Opcode in bits 7:4, payload in bits 3:0 |
| rsp_valid | output | 1 | Response byte present |
| rsp_ready | input | 1 | Consumer takes the response this cycle |
| rsp_byte | output | 8 | Register byte returned by a read |
| cap_trig_pos | input | 24 | Trigger position from the capture engine |
| cap_stop_pos | input | 24 | Stop position from the capture engine |
| cap_triggered | input | 1 | Capture engine reports its trigger condition |
| cap_run | output | 1 | Capture enable |
| cap_readback | output | 1 | Memory readback enable |
| cfg_out | output | 32 | Configuration bytes, byte i from address 0x08+i |

## Verification
In a single cycle, the block can both hand off the response it holds and accept a new read that refills the response slot. The bench provokes this in two ways. The first is a run of six read-and-step commands with rsp_ready held high. It is judged by counting that the run takes exactly six clock cycles, and by comparing the six returned bytes, in order, against the model's position bytes. The second is a stall: rsp_ready is held low while a second read waits. The bench checks that the first byte stays stable and cmd_ready stays low during the stall. When rsp_ready is released, the old byte and then the new byte must arrive in order, with nothing lost and nothing repeated.

// File: rtl/nibreg_pkg.sv
// Shared opcodes, mode command codes, status bit positions and the decoded
// access record used between the command decoder and the register bank.
package nibreg_pkg;

    localparam logic [3:0] OP_ADDR_LO  = 4'h0;
    localparam logic [3:0] OP_ADDR_HI  = 4'h1;
    localparam logic [3:0] OP_DATA_LO  = 4'h2;
    localparam logic [3:0] OP_DATA_WR  = 4'h3;
    localparam logic [3:0] OP_READ     = 4'h4;
    localparam logic [3:0] OP_READ_INC = 4'h5;

    localparam logic [7:0] MODE_START  = 8'h0D;
    localparam logic [7:0] MODE_STOP   = 8'h11;
    localparam logic [7:0] MODE_RDBACK = 8'h02;

    localparam int STAT_RUN_BIT  = 0;
    localparam int STAT_RDB_BIT  = 1;
    localparam int STAT_TRIG_BIT = 5;

    typedef struct packed {
        logic       wr;
        logic       rd;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_acc_t;

endpackage

// File: rtl/nibreg_cmd.sv
// Command decoder: splits each accepted byte into opcode and payload, keeps
// the register pointer and the pending low data nibble, and issues one
// register access per accepted write or read command.
// Assumes take is high only in cycles where a command byte is handed over.
module nibreg_cmd
    import nibreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic [7:0] cmd_byte,
    output reg_acc_t   acc
);

    logic [3:0] op;
    logic [3:0] nib;
    logic [7:0] ptr;
    logic [3:0] lo_q;
    logic       is_rd;
    logic       is_step;

    assign op  = cmd_byte[7:4];
    assign nib = cmd_byte[3:0];

    // Classify read commands and commands that advance the pointer.
    always_comb begin
        is_rd   = (op == OP_READ) || (op == OP_READ_INC);
        is_step = (op == OP_READ_INC) || (op == OP_DATA_WR);
    end

    // Pointer and pending-nibble state, updated only by recognised opcodes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= 8'h00;
            lo_q <= 4'h0;
        end else if (take) begin
            case (op)
                OP_ADDR_LO: ptr[3:0] <= nib;
                OP_ADDR_HI: ptr[7:4] <= nib;
                OP_DATA_LO: lo_q     <= nib;
                default: begin
                    if (is_step) ptr <= ptr + 8'd1;
                end
            endcase
        end
    end

    // Access record presented to the register bank in the acceptance cycle.
    always_comb begin
        acc.wr   = take && (op == OP_DATA_WR);
        acc.rd   = take && is_rd;
        acc.addr = ptr;
        acc.data = {nib, lo_q};
    end

    // R3
    step_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_READ_INC) |=> (ptr == $past(ptr) + 8'd1));

    // R3
    plain_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_READ) |=> $stable(ptr));

    // R9
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op > OP_READ_INC) |=> ($stable(ptr) && $stable(lo_q)));

    // R1
    addr_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op == OP_ADDR_HI) |=> (ptr[3:0] == $past(ptr[3:0])));

endmodule

// File: rtl/nibreg_regs.sv
// Register bank: position snapshot, mode state with its status byte, and a
// parameterised bank of configuration bytes. Provides the combinational read
// byte for the address carried in the access record.
// Assumes POS_W is a multiple of 8 and all addresses fit in 8 bits.
module nibreg_regs
    import nibreg_pkg::*;
#(
    parameter int POS_W     = 24,
    parameter int CFG_BYTES = 4,
    parameter int CFG_BASE  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  reg_acc_t               acc,
    input  logic [POS_W-1:0]       cap_trig_pos,
    input  logic [POS_W-1:0]       cap_stop_pos,
    input  logic                   cap_triggered,
    output logic [7:0]             rd_data,
    output logic                   run,
    output logic                   rdback,
    output logic [8*CFG_BYTES-1:0] cfg_out
);

    localparam int         POS_BYTES = POS_W / 8;
    localparam int         STOP_BASE = POS_BYTES;
    localparam logic [7:0] MODE_ADDR = 8'(2 * POS_BYTES);

    logic [POS_W-9:0] snap_trig;
    logic [POS_W-1:0] snap_stop;
    logic             trig_seen;
    logic [7:0]       status;
    logic             mode_wr;
    logic             snap_take;

    assign mode_wr   = acc.wr && (acc.addr == MODE_ADDR);
    assign snap_take = acc.rd && (acc.addr == 8'h00);

    // Snapshot both positions when the first trigger byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_trig <= '0;
            snap_stop <= '0;
        end else if (snap_take) begin
            snap_trig <= cap_trig_pos[POS_W-1:8];
            snap_stop <= cap_stop_pos;
        end
    end

    // Mode state driven by the three recognised command values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run    <= 1'b0;
            rdback <= 1'b0;
        end else if (mode_wr) begin
            case (acc.data)
                MODE_START: begin
                    run    <= 1'b1;
                    rdback <= 1'b0;
                end
                MODE_STOP:   run    <= 1'b0;
                MODE_RDBACK: rdback <= 1'b1;
                default: ;
            endcase
        end
    end

    // Sticky trigger flag: cleared by a start command, set while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_seen <= 1'b0;
        end else if (mode_wr && acc.data == MODE_START) begin
            trig_seen <= 1'b0;
        end else if (run && cap_triggered) begin
            trig_seen <= 1'b1;
        end
    end

    // Status byte assembled from mode state.
    always_comb begin
        status                = 8'h00;
        status[STAT_RUN_BIT]  = run;
        status[STAT_RDB_BIT]  = rdback;
        status[STAT_TRIG_BIT] = trig_seen;
    end

    // Configuration bytes, one register per byte.
    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_cfg
        localparam logic [7:0] ADDR = 8'(CFG_BASE + g);
        logic [7:0] cfg_q;

        // Load this byte on a write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q <= 8'h00;
            end else if (acc.wr && acc.addr == ADDR) begin
                cfg_q <= acc.data;
            end
        end

        assign cfg_out[8*g +: 8] = cfg_q;

        // R7
        cfg_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc.wr && acc.addr == ADDR) |=> (cfg_out[8*g +: 8] == $past(acc.data)));
    end

    // Read multiplexer: unmapped addresses fall through to zero.
    always_comb begin
        rd_data = 8'h00;
        if (acc.addr == 8'h00) rd_data = cap_trig_pos[7:0];
        for (int i = 1; i < POS_BYTES; i++) begin
            if (acc.addr == 8'(i)) rd_data = snap_trig[8*(i-1) +: 8];
        end
        for (int i = 0; i < POS_BYTES; i++) begin
            if (acc.addr == 8'(STOP_BASE + i)) rd_data = snap_stop[8*i +: 8];
        end
        if (acc.addr == MODE_ADDR) rd_data = status;
        for (int i = 0; i < CFG_BYTES; i++) begin
            if (acc.addr == 8'(CFG_BASE + i)) rd_data = cfg_out[8*i +: 8];
        end
    end

    // R5
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && acc.data == MODE_START) |=> (run && !rdback && !trig_seen));

    // R5
    stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wr && acc.data == MODE_STOP) |=> !run);

    // R6
    trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_seen) |-> ($past(run) && $past(cap_triggered)));

    // R4
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_take |=> $stable(snap_stop));

endmodule

// File: rtl/nibreg_rsp.sv
// Response slot: a single holding register for read results. It reports
// whether a new read may be accepted this cycle, which is true when the slot
// is empty or is being emptied in the same cycle.
module nibreg_rsp (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       rsp_ready,
    output logic       rsp_valid,
    output logic [7:0] rsp_byte,
    output logic       can_take
);

    assign can_take = !rsp_valid || rsp_ready;

    // Fill on a read, empty on handoff; a fill wins when both happen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= 8'h00;
        end else if (load) begin
            rsp_valid <= 1'b1;
            rsp_byte  <= din;
        end else if (rsp_ready) begin
            rsp_valid <= 1'b0;
        end
    end

    // R10
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_byte)));

endmodule

// File: rtl/nibreg_port.sv
// Top level: command handshake, decoder, register bank and response slot.
// A command is taken whenever the response slot can absorb a possible read.
module nibreg_port
    import nibreg_pkg::*;
#(
    parameter int POS_W     = 24,
    parameter int CFG_BYTES = 4,
    parameter int CFG_BASE  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_valid,
    output logic                   cmd_ready,
    input  logic [7:0]             cmd_byte,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [7:0]             rsp_byte,
    input  logic [POS_W-1:0]       cap_trig_pos,
    input  logic [POS_W-1:0]       cap_stop_pos,
    input  logic                   cap_triggered,
    output logic                   cap_run,
    output logic                   cap_readback,
    output logic [8*CFG_BYTES-1:0] cfg_out
);

    reg_acc_t   acc;
    logic       take;
    logic [7:0] rd_data;
    logic       can_take;

    assign cmd_ready = can_take;
    assign take      = cmd_valid && cmd_ready;

    nibreg_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .cmd_byte (cmd_byte),
        .acc      (acc)
    );

    nibreg_regs #(
        .POS_W     (POS_W),
        .CFG_BYTES (CFG_BYTES),
        .CFG_BASE  (CFG_BASE)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc           (acc),
        .cap_trig_pos  (cap_trig_pos),
        .cap_stop_pos  (cap_stop_pos),
        .cap_triggered (cap_triggered),
        .rd_data       (rd_data),
        .run           (cap_run),
        .rdback        (cap_readback),
        .cfg_out       (cfg_out)
    );

    nibreg_rsp u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (acc.rd),
        .din       (rd_data),
        .rsp_ready (rsp_ready),
        .rsp_valid (rsp_valid),
        .rsp_byte  (rsp_byte),
        .can_take  (can_take)
    );

    // R3
    read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (cmd_byte[7:4] == OP_READ || cmd_byte[7:4] == OP_READ_INC)) |=> rsp_valid);

    // R9
    bad_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_byte[7:4] > OP_READ_INC && !rsp_valid) |=> !rsp_valid);

endmodule

// File: tb/nibreg_port_test.sv
module nibreg_port_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int POS_W     = 24;
    localparam int CFG_BYTES = 4;
    localparam int CFG_BASE  = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cmd_valid = 1'b0;
    logic                   cmd_ready;
    logic [7:0]             cmd_byte = 8'h00;
    logic                   rsp_valid;
    logic                   rsp_ready = 1'b1;
    logic [7:0]             rsp_byte;
    logic [POS_W-1:0]       cap_trig_pos = '0;
    logic [POS_W-1:0]       cap_stop_pos = '0;
    logic                   cap_triggered = 1'b0;
    logic                   cap_run;
    logic                   cap_readback;
    logic [8*CFG_BYTES-1:0] cfg_out;

    nibreg_port #(.POS_W(POS_W), .CFG_BYTES(CFG_BYTES), .CFG_BASE(CFG_BASE)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_byte(cmd_byte), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_byte(rsp_byte), .cap_trig_pos(cap_trig_pos), .cap_stop_pos(cap_stop_pos),
        .cap_triggered(cap_triggered), .cap_run(cap_run), .cap_readback(cap_readback),
        .cfg_out(cfg_out)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    string cur_tag = "R3";

    always @(posedge clk) cyc <= cyc + 1;

    // Reference model state
    logic [7:0]       m_ptr = 8'h00;
    logic [3:0]       m_lo = 4'h0;
    logic [7:0]       m_cfg [CFG_BYTES];
    logic             m_run = 1'b0;
    logic             m_rdb = 1'b0;
    logic             m_tseen = 1'b0;
    logic [POS_W-1:0] m_st = '0;
    logic [POS_W-1:0] m_ss = '0;

    logic [7:0] rq[$];
    logic [7:0] exq[$];
    string      tagq[$];

    // Response collector, sampled well after the falling edge.
    always begin
        @(negedge clk);
        #2;
        if (rsp_valid && rsp_ready) rq.push_back(rsp_byte);
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] status_byte();
        logic [7:0] s = 8'h00;
        s[0] = m_run;
        s[1] = m_rdb;
        s[5] = m_tseen;
        return s;
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        if (a == 8'h00) return cap_trig_pos[7:0];
        if (a == 8'h01) return m_st[15:8];
        if (a == 8'h02) return m_st[23:16];
        if (a == 8'h03) return m_ss[7:0];
        if (a == 8'h04) return m_ss[15:8];
        if (a == 8'h05) return m_ss[23:16];
        if (a == 8'h06) return status_byte();
        if (a >= 8'(CFG_BASE) && a < 8'(CFG_BASE + CFG_BYTES)) return m_cfg[a - 8'(CFG_BASE)];
        return 8'h00;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h06) begin
            if (d == 8'h0D) begin m_run = 1'b1; m_rdb = 1'b0; m_tseen = 1'b0; end
            else if (d == 8'h11) m_run = 1'b0;
            else if (d == 8'h02) m_rdb = 1'b1;
        end else if (a >= 8'(CFG_BASE) && a < 8'(CFG_BASE + CFG_BYTES)) begin
            m_cfg[a - 8'(CFG_BASE)] = d;
        end
    endtask

    task automatic model_apply(input logic [7:0] b);
        logic [3:0] op = b[7:4];
        logic [3:0] n = b[3:0];
        case (op)
            4'h0: m_ptr[3:0] = n;
            4'h1: m_ptr[7:4] = n;
            4'h2: m_lo = n;
            4'h3: begin model_write(m_ptr, {n, m_lo}); m_ptr = m_ptr + 8'd1; end
            4'h4, 4'h5: begin
                exq.push_back(exp_read(m_ptr));
                tagq.push_back(cur_tag);
                if (m_ptr == 8'h00) begin m_st = cap_trig_pos; m_ss = cap_stop_pos; end
                if (op == 4'h5) m_ptr = m_ptr + 8'd1;
            end
            default: ;
        endcase
    endtask

    // Drive one command; called aligned to a falling edge, returns on one.
    task automatic send(input logic [7:0] b);
        bit acc;
        cmd_valid = 1'b1;
        cmd_byte  = b;
        do begin
            #1 acc = cmd_ready;
            @(negedge clk);
        end while (!acc);
        cmd_valid = 1'b0;
        model_apply(b);
    endtask

    task automatic set_addr(input logic [7:0] a);
        send({4'h0, a[3:0]});
        send({4'h1, a[7:4]});
    endtask

    task automatic wr_byte(input logic [7:0] d);
        send({4'h2, d[3:0]});
        send({4'h3, d[7:4]});
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
        while (exq.size() > 0) begin
            logic [7:0] e = exq.pop_front();
            string t = tagq.pop_front();
            if (rq.size() == 0) begin
                chk({t, " missing response"}, 32'hDEAD, {24'h0, e});
            end else begin
                chk(t, {24'h0, rq.pop_front()}, {24'h0, e});
            end
        end
        chk("R9 no extra responses", rq.size(), 0);
        rq.delete();
    endtask

    function automatic logic [8*CFG_BYTES-1:0] cfg_flat();
        logic [8*CFG_BYTES-1:0] f;
        for (int i = 0; i < CFG_BYTES; i++) f[8*i +: 8] = m_cfg[i];
        return f;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed_dummy;
        logic [7:0] held;
        int t0;
        seed_dummy = $urandom(32'h1A2B);
        for (int i = 0; i < CFG_BYTES; i++) m_cfg[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        #1;
        chk("R11 rsp_valid", rsp_valid, 0);
        chk("R11 cmd_ready", cmd_ready, 1);
        chk("R11 cap_run", cap_run, 0);
        chk("R11 cap_readback", cap_readback, 0);
        chk("R11 cfg_out", cfg_out, 0);
        @(negedge clk);
        cur_tag = "R11 snapshot";
        set_addr(8'h01);
        send(8'h50); send(8'h50); send(8'h50);
        drain();

        // R4 positions, snapshot and order; R3 step reads
        cap_trig_pos = 24'hA1B2C3;
        cap_stop_pos = 24'h0D0E0F;
        cur_tag = "R4 position burst";
        set_addr(8'h00);
        send(8'h50);
        cap_trig_pos = 24'h111111;
        cap_stop_pos = 24'h222222;
        send(8'h50); send(8'h50); send(8'h50); send(8'h50); send(8'h50);
        drain();
        chk("R4 snapshot trig byte2", {24'h0, m_st[23:16]}, 32'hA1);

        // R3 plain read keeps pointer; R1 address halves
        cur_tag = "R3 plain read";
        set_addr(8'h04);
        send(8'h40); send(8'h40);
        cur_tag = "R1 low half only";
        send(8'h03);
        send(8'h40);
        drain();

        // R5 / R6 mode and status
        cur_tag = "R6 status";
        set_addr(8'h06); wr_byte(8'h0D);
        chk("R5 start run", cap_run, 1);
        set_addr(8'h06); send(8'h40);
        cap_triggered = 1'b1;
        repeat (2) @(negedge clk);
        cap_triggered = 1'b0;
        m_tseen = m_tseen | m_run;
        send(8'h40);
        set_addr(8'h06); wr_byte(8'h11);
        chk("R5 stop run", cap_run, 0);
        set_addr(8'h06); wr_byte(8'h02);
        chk("R5 readback", cap_readback, 1);
        set_addr(8'h06); wr_byte(8'h55);
        chk("R5 ignored value run", cap_run, 0);
        chk("R5 ignored value readback", cap_readback, 1);
        set_addr(8'h06); send(8'h40);
        drain();
        chk("R6 trigger flag modelled", m_tseen, 1);
        cur_tag = "R5 restart clears";
        set_addr(8'h06); wr_byte(8'h0D);
        set_addr(8'h06); send(8'h40);
        drain();
        chk("R5 restart readback", cap_readback, 0);

        // R7 / R2 configuration burst
        cur_tag = "R7 cfg readback";
        set_addr(8'h08);
        wr_byte(8'h5A); wr_byte(8'hC3); wr_byte(8'h01); wr_byte(8'hFE);
        chk("R7 cfg_out burst", cfg_out, 32'hFE01C35A);
        set_addr(8'h08);
        send(8'h50); send(8'h50); send(8'h50); send(8'h50);
        drain();

        // R8 discarded writes and empty reads
        cur_tag = "R8 unmapped";
        set_addr(8'h07); wr_byte(8'h77);
        set_addr(8'h20); wr_byte(8'h99);
        set_addr(8'h01); wr_byte(8'h44);
        set_addr(8'h07); send(8'h40);
        set_addr(8'h20); send(8'h40);
        set_addr(8'h01); send(8'h40);
        drain();
        chk("R8 cfg unchanged", cfg_out, 32'hFE01C35A);

        // R9 ignored opcodes
        set_addr(8'h09);
        send(8'h6F); send(8'h9A); send(8'hF0);
        repeat (3) @(negedge clk);
        chk("R9 no response", rq.size(), 0);
        cur_tag = "R9 pointer kept";
        send(8'h40);
        set_addr(8'h0B);
        send(8'h25); send(8'h7C); send(8'h3A);
        chk("R9 pending nibble kept", cfg_out[31:24], 8'hA5);
        drain();

        // R3 pointer wrap
        cur_tag = "R3 wrap";
        set_addr(8'hFF);
        send(8'h50); send(8'h40);
        drain();

        // R10 full-rate reads: handoff and refill in the same cycle
        cur_tag = "R10 full rate";
        set_addr(8'h00);
        t0 = cyc;
        send(8'h50); send(8'h50); send(8'h50); send(8'h50); send(8'h50); send(8'h50);
        chk("R10 six reads in six cycles", cyc - t0, 6);
        drain();

        // R10 stall
        cur_tag = "R10 stall";
        rsp_ready = 1'b0;
        set_addr(8'h08);
        send(8'h40);
        held = rsp_byte;
        fork
            send(8'h50);
            begin
                repeat (3) begin
                    #1.5;
                    chk("R10 cmd_ready low", cmd_ready, 0);
                    chk("R10 rsp_valid held", rsp_valid, 1);
                    chk("R10 rsp_byte stable", rsp_byte, held);
                    @(negedge clk);
                end
                rsp_ready = 1'b1;
            end
        join
        drain();

        // Random phase
        cur_tag = "R3 random";
        for (int k = 0; k < 500; k++) begin
            int unsigned r = $urandom_range(0, 9);
            logic [3:0] n = 4'($urandom_range(0, 15));
            case (r)
                0: begin
                    cap_trig_pos = 24'($urandom);
                    cap_stop_pos = 24'($urandom);
                    @(negedge clk);
                end
                1: send({4'h0, n});
                2: send({4'h1, ($urandom_range(0, 7) == 0) ? n : 4'h0});
                3: send({4'h2, n});
                4: send({4'h3, n});
                5, 6: send({4'h4, n});
                7, 8: send({4'h5, n});
                default: send({4'($urandom_range(6, 15)), n});
            endcase
        end
        drain();
        chk("R7 cfg_out after random", cfg_out, cfg_flat());
        chk("R5 run after random", cap_run, m_run);
        chk("R5 readback after random", cap_readback, m_rdb);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule